// File: doc/BRIEF.md
# Asynchronous serial transceiver with loopback and receiver sleep

This block is a full-duplex asynchronous serial port. A transmitter turns a character of eight or nine bits into a framed bit stream on `txd`. A receiver recovers characters by sampling its input line at sixteen times the bit rate. Both halves share one baud generator, which produces an oversampling tick every `baud_div` clock cycles. Characters move in and out of the block through valid/ready handshakes. Received characters carry parity, framing and overrun flags.

The receiver input comes from one of three places. In normal operation it is the `rxd` pin. In internal loopback it is the transmitter's own output register. In external loopback it is the level read back from the transmit pad (`txd_pad_in`). Loopback takes effect only while both halves are enabled. The receiver can be put to sleep so that it ignores traffic meant for other nodes. It wakes either after a full character time of idle line or on a character whose top data bit is 1. A halt control freezes the whole block while a wait-mode input is high.

Top module: `uart_lw`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `txd` is 1, `rx_valid`, `parity_err`, `frame_err`, `overrun` and `rx_asleep` are 0, and `tx_ready` equals `tx_en`.
- R2: A frame is one start bit (0), then the data bits least significant first, then one stop bit (1). There are 8 data bits when `nine_bit`=0 and 9 when it is 1. Each bit lasts 16 periods of `baud_div` clock cycles, and the line idles at 1. A `baud_div` of 0 stops all bit timing, so nothing is sent or received.
- R3: `tx_ready` is high only when `tx_en` is 1, the transmitter is idle and the block is not halted. After an accepted request it stays low until the stop bit has finished.
- R4: With `parity_en`=1 the top data bit (bit 7 in 8-bit mode, bit 8 in 9-bit mode) is replaced by a parity bit over the bits below it. The parity bit gives an even count of ones when `parity_odd`=0 and an odd count when `parity_odd`=1. A received character whose data bits fail this rule raises `parity_err`.
- R5: The receiver delivers each character on `rx_data`, with the first bit received at bit 0 and bit 8 forced to 0 in 8-bit mode. It raises `rx_valid` and holds the character and its flags until `rx_ready` is seen high. A start bit must still read 0 by majority of the middle samples, or it is dropped.
- R6: A stop bit that reads 0 delivers the character with `frame_err` set.
- R7: A character that completes while `rx_valid` is still high is discarded and sets `overrun`. The held character is unchanged, and a read clears all three flags.
- R8: With `loop_sel`=1, `loop_ext`=0 and both enables set, the receiver takes the transmitter output internally and ignores both `rxd` and `txd_pad_in`.
- R9: With `loop_sel`=1, `loop_ext`=1 and both enables set, the receiver takes `txd_pad_in` and ignores `rxd`.
- R10: When either enable is 0, `loop_sel` has no effect and the receiver listens on `rxd`.
- R11: A one-cycle `sleep_req` pulse sets `rx_asleep`. While asleep, characters that do not wake the receiver raise no `rx_valid`.
- R12: With `wake_addr`=1, a character whose top data bit is 1 clears `rx_asleep` and is delivered. An idle line does not wake the receiver in this mode.
- R13: With `wake_addr`=0, `rx_asleep` clears after a full character time (10 or 11 bit times) of continuous 1 on the receiver input.
- R14: While `stop_in_wait` and `wait_mode` are both 1, the block is frozen. `tx_ready` is 0, `txd` holds its level and bit timing pauses. With `stop_in_wait`=0, `wait_mode` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_div | input | 13 | Clock cycles per oversampling tick; 0 stops the baud generator |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| nine_bit | input | 1 | 0: 8 data bits, 1: 9 data bits |
| parity_en | input | 1 | Parity replaces the top data bit |
| parity_odd | input | 1 | 0: even parity, 1: odd parity |
| loop_sel | input | 1 | Loopback select |
| loop_ext | input | 1 | In loopback, 0: internal path, 1: transmit pad read-back |
| wake_addr | input | 1 | Wake condition, 0: idle line, 1: top data bit set |
| sleep_req | input | 1 | Pulse that puts the receiver to sleep |
| stop_in_wait | input | 1 | Freeze the block while `wait_mode` is high |
| wait_mode | input | 1 | Wait-mode indication |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | Transmit request |
| tx_ready | output | 1 | Transmitter can accept a character |
| txd | output | 1 | Serial output, idles high |
| txd_pad_in | input | 1 | Level read back from the transmit pad |
| rxd | input | 1 | Serial input pin |
| rx_data | output | 9 | Received character |
| rx_valid | output | 1 | Received character is held |
| rx_ready | input | 1 | Consumer takes the held character |
| parity_err | output | 1 | Held character failed the parity check |
| frame_err | output | 1 | Held character had a 0 stop bit |
| overrun | output | 1 | A character was lost while one was held |
| rx_asleep | output | 1 | Receiver is asleep |

## Verification
The transmitter is tried with 8-bit, 9-bit and parity-bearing characters. A character-level model decodes `txd` at mid-bit, which separates bit-order, framing and parity-sense faults. Frame duration is measured free-running and with a freeze in the middle, to show that timing counts ticks and that the halt pauses it. The receiver is driven with clean frames, a parity mismatch, a short low stop bit (which also tests start rejection), back-to-back unread characters, and loopback with `rxd` held low and the pad read-back either following `txd` or stuck high, so that the chosen source is identified. Sleep is tried with a non-address character, a long idle in address mode, an address character, and an idle gap timed just short of and just past one character time.

// File: rtl/uart_lw_pkg.sv
package uart_lw_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Parity bit over the data bits below the top one of the character.
  function automatic logic low_parity(input logic [8:0] d, input logic nine, input logic odd);
    return (nine ? ^d[7:0] : ^d[6:0]) ^ odd;
  endfunction

endpackage

// File: rtl/uart_lw_baud.sv
module uart_lw_baud #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (run) begin
        if (div == '0) begin
          cnt <= '0;
        end else if (cnt >= div - 1'b1) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_lw_tx.sv
module uart_lw_tx
  import uart_lw_pkg::*;
#(
  parameter int OVS_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       en,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [8:0] data,
  input  logic       valid,
  output logic       ready,
  output logic       line
);
  localparam int FRAME_W = 11;

  logic                busy;
  logic [FRAME_W-1:0]  shreg;
  logic [3:0]          bitn;
  logic [OVS_LOG2-1:0] sc;
  logic [8:0]          body;
  logic [FRAME_W-1:0]  frame;
  logic [3:0]          last_bit;

  always_comb begin
    body = data;
    if (par_en) begin
      if (nine) body[8] = low_parity(data, 1'b1, par_odd);
      else      body[7] = low_parity(data, 1'b0, par_odd);
    end
    frame    = nine ? {1'b1, body, 1'b0} : {2'b11, body[7:0], 1'b0};
    last_bit = nine ? 4'd10 : 4'd9;
  end

  assign ready = en & ~busy & run;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      shreg <= '1;
      bitn  <= '0;
      sc    <= '0;
      line  <= 1'b1;
    end else if (!busy) begin
      line <= 1'b1;
      if (valid && ready) begin
        busy  <= 1'b1;
        shreg <= frame;
        bitn  <= '0;
        sc    <= '0;
        line  <= frame[0];
      end
    end else if (tick) begin
      if (sc == '1) begin
        sc <= '0;
        if (bitn == last_bit) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          bitn  <= bitn + 1'b1;
          shreg <= shreg >> 1;
          line  <= shreg[1];
        end
      end else begin
        sc <= sc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_lw_rx.sv
module uart_lw_rx
  import uart_lw_pkg::*;
#(
  parameter int OVS_LOG2 = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       tick,
  input  logic       en,
  input  logic       nine,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       wake_addr,
  input  logic       sleep_req,
  input  logic       line_in,
  input  logic       rd,
  output logic [8:0] data,
  output logic       valid,
  output logic       perr,
  output logic       ferr,
  output logic       ovr,
  output logic       asleep
);
  localparam int OVS    = 1 << OVS_LOG2;
  localparam int IDLE_W = OVS_LOG2 + 4;
  localparam logic [OVS_LOG2-1:0] S_A = OVS_LOG2'(OVS / 2 - 1);
  localparam logic [OVS_LOG2-1:0] S_B = OVS_LOG2'(OVS / 2);
  localparam logic [OVS_LOG2-1:0] S_C = OVS_LOG2'(OVS / 2 + 1);
  localparam logic [IDLE_W-1:0] CHAR8 = IDLE_W'(OVS * 10 - 1);
  localparam logic [IDLE_W-1:0] CHAR9 = IDLE_W'(OVS * 11 - 1);

  rx_state_e           st;
  logic [1:0]          sync;
  logic [OVS_LOG2-1:0] sc;
  logic [3:0]          bitn;
  logic [8:0]          shreg;
  logic                s_a, s_b;
  logic [IDLE_W-1:0]   idle_cnt;

  logic       cur, maj, msb, pe, take, held, let_in;
  logic [8:0] got;
  logic [3:0] last_data;
  logic [IDLE_W-1:0] char_last;

  always_comb begin
    cur       = sync[1];
    maj       = (s_a & s_b) | (s_a & cur) | (s_b & cur);
    got       = nine ? shreg : {1'b0, shreg[8:1]};
    msb       = nine ? got[8] : got[7];
    pe        = par_en & ((^got) ^ par_odd);
    last_data = nine ? 4'd8 : 4'd7;
    char_last = nine ? CHAR9 : CHAR8;
    take      = run & rd & valid;
    held      = valid & ~take;
    let_in    = ~asleep | (wake_addr & msb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      sync     <= 2'b11;
      sc       <= '0;
      bitn     <= '0;
      shreg    <= '0;
      s_a      <= 1'b1;
      s_b      <= 1'b1;
      idle_cnt <= '0;
      data     <= '0;
      valid    <= 1'b0;
      perr     <= 1'b0;
      ferr     <= 1'b0;
      ovr      <= 1'b0;
      asleep   <= 1'b0;
    end else begin
      sync <= {sync[0], line_in};
      if (take) begin
        valid <= 1'b0;
        perr  <= 1'b0;
        ferr  <= 1'b0;
        ovr   <= 1'b0;
      end
      if (!en) begin
        st       <= RX_IDLE;
        sc       <= '0;
        idle_cnt <= '0;
      end else if (tick) begin
        if (st == RX_IDLE) begin
          if (!cur) begin
            st       <= RX_START;
            sc       <= '0;
            idle_cnt <= '0;
          end else begin
            if (idle_cnt != '1) idle_cnt <= idle_cnt + 1'b1;
            if (asleep && !wake_addr && idle_cnt == char_last) asleep <= 1'b0;
          end
        end else begin
          sc <= sc + 1'b1;
          if (sc == S_A) s_a <= cur;
          if (sc == S_B) s_b <= cur;
          if (sc == S_C) begin
            case (st)
              RX_START: if (maj) st <= RX_IDLE;
              RX_DATA:  shreg <= {maj, shreg[8:1]};
              RX_STOP: begin
                st <= RX_IDLE;
                if (let_in) begin
                  if (asleep) asleep <= 1'b0;
                  if (held) begin
                    ovr <= 1'b1;
                  end else begin
                    data  <= got;
                    valid <= 1'b1;
                    perr  <= pe;
                    ferr  <= ~maj;
                  end
                end
              end
              default: st <= RX_IDLE;
            endcase
          end
          if (sc == '1) begin
            if (st == RX_START) begin
              st   <= RX_DATA;
              bitn <= '0;
            end else if (st == RX_DATA) begin
              if (bitn == last_data) st <= RX_STOP;
              else bitn <= bitn + 1'b1;
            end
          end
        end
      end
      if (run && sleep_req) begin
        asleep   <= 1'b1;
        idle_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/uart_lw.sv
module uart_lw #(
  parameter int DIV_W    = 13,
  parameter int OVS_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             nine_bit,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             loop_sel,
  input  logic             loop_ext,
  input  logic             wake_addr,
  input  logic             sleep_req,
  input  logic             stop_in_wait,
  input  logic             wait_mode,
  input  logic [8:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  input  logic             txd_pad_in,
  input  logic             rxd,
  output logic [8:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             parity_err,
  output logic             frame_err,
  output logic             overrun,
  output logic             rx_asleep
);
  logic run, tick_raw, tick, loop_on, rx_line;

  assign run     = ~(stop_in_wait & wait_mode);
  assign tick    = tick_raw & run;
  assign loop_on = loop_sel & tx_en & rx_en;
  assign rx_line = loop_on ? (loop_ext ? txd_pad_in : txd) : rxd;

  uart_lw_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst(rst), .run(run), .div(baud_div), .tick(tick_raw)
  );

  uart_lw_tx #(.OVS_LOG2(OVS_LOG2)) tx_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .en(tx_en),
    .nine(nine_bit), .par_en(parity_en), .par_odd(parity_odd),
    .data(tx_data), .valid(tx_valid), .ready(tx_ready), .line(txd)
  );

  uart_lw_rx #(.OVS_LOG2(OVS_LOG2)) rx_i (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .en(rx_en),
    .nine(nine_bit), .par_en(parity_en), .par_odd(parity_odd),
    .wake_addr(wake_addr), .sleep_req(sleep_req), .line_in(rx_line),
    .rd(rx_ready), .data(rx_data), .valid(rx_valid), .perr(parity_err),
    .ferr(frame_err), .ovr(overrun), .asleep(rx_asleep)
  );
endmodule

// File: rtl/uart_lw_chk.sv
module uart_lw_chk (
  input logic       clk,
  input logic       rst,
  input logic       tx_en,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic [8:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic       rx_asleep,
  input logic       stop_in_wait,
  input logic       wait_mode
);
  // R2: an idle transmitter leaves the line high
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd);

  // R3: an accepted request makes the transmitter busy
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R3: no acceptance while the transmitter is disabled
  a_r3_ready_needs_en: assert property (@(posedge clk) disable iff (rst)
    !tx_en |-> !tx_ready);

  // R5: an unread character stays put
  a_r5_hold_data: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R11: a sleeping receiver raises no strobe unless it wakes at once
  a_r11_sleep_silent: assert property (@(posedge clk) disable iff (rst)
    (rx_asleep && !rx_valid) |=> (!rx_valid || !rx_asleep));

  // R14: frozen transmit line while halted
  a_r14_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    (stop_in_wait && wait_mode) |=> $stable(txd));

  // R14: no acceptance while halted
  a_r14_halt_not_ready: assert property (@(posedge clk) disable iff (rst)
    (stop_in_wait && wait_mode) |-> !tx_ready);
endmodule

bind uart_lw uart_lw_chk chk_i (
  .clk(clk), .rst(rst), .tx_en(tx_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .txd(txd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_asleep(rx_asleep), .stop_in_wait(stop_in_wait), .wait_mode(wait_mode)
);

// File: tb/uart_lw_tb_top.sv
module uart_lw_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int BIT        = 16 * DIV;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [12:0] baud_div = 13'(DIV);
  logic tx_en = 1'b1, rx_en = 1'b1, nine_bit = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic loop_sel = 1'b0, loop_ext = 1'b0, wake_addr = 1'b0, sleep_req = 1'b0;
  logic stop_in_wait = 1'b0, wait_mode = 1'b0;
  logic [8:0] tx_data = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic rxd_drv = 1'b1, pad_stuck = 1'b0;
  logic tx_ready, txd, txd_pad_in, rxd, rx_valid, parity_err, frame_err, overrun, rx_asleep;
  logic [8:0] rx_data;

  int total = 0;
  int bad   = 0;
  bit allow_rx = 1'b0;
  logic rx_valid_d = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rxd        = rxd_drv;
  assign txd_pad_in = pad_stuck ? 1'b1 : txd;

  uart_lw dut_i (
    .clk(clk), .rst(rst), .baud_div(baud_div), .tx_en(tx_en), .rx_en(rx_en),
    .nine_bit(nine_bit), .parity_en(parity_en), .parity_odd(parity_odd),
    .loop_sel(loop_sel), .loop_ext(loop_ext), .wake_addr(wake_addr),
    .sleep_req(sleep_req), .stop_in_wait(stop_in_wait), .wait_mode(wait_mode),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
    .txd_pad_in(txd_pad_in), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .parity_err(parity_err), .frame_err(frame_err),
    .overrun(overrun), .rx_asleep(rx_asleep)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Per-clock model: a character may only appear when a test expects one (R11)
  always @(negedge clk) begin
    if (!rst && rx_valid && !rx_valid_d && !allow_rx) begin
      total++;
      bad++;
      $display("FAIL R11 unexpected character actual=%0h expected=none", rx_data);
    end
    rx_valid_d <= rx_valid;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_frame(input logic [8:0] d, input bit nine, input bit good_stop);
    rxd_drv = 1'b0;
    wait_clk(BIT);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rxd_drv = d[i];
      wait_clk(BIT);
    end
    if (good_stop) begin
      rxd_drv = 1'b1;
      wait_clk(BIT);
    end else begin
      rxd_drv = 1'b0;
      wait_clk(48);
      rxd_drv = 1'b1;
      wait_clk(BIT);
    end
  endtask

  task automatic wait_rx(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (rx_valid) seen = 1'b1;
      else @(negedge clk);
    end
  endtask

  task automatic read_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic send_tx(input logic [8:0] d);
    for (int i = 0; i < 5000 && !tx_ready; i++) @(negedge clk);
    tx_data  = d;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic decode_tx(input int nb, output logic [8:0] v, output logic stop_bit);
    v = '0;
    for (int i = 0; i < 3000 && txd; i++) @(negedge clk);
    wait_clk(BIT / 2);
    chk("R2 start bit", int'(txd), 0);
    for (int i = 0; i < nb; i++) begin
      wait_clk(BIT);
      v[i] = txd;
    end
    wait_clk(BIT);
    stop_bit = txd;
  endtask

  function automatic logic [8:0] with_par8(input logic [8:0] d, input logic odd);
    return {1'b0, (^d[6:0]) ^ odd, d[6:0]};
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [8:0] v;
    logic sb;
    bit seen;
    int n;

    wait_clk(3);
    // R1: reset state
    chk("R1 txd", int'(txd), 1);
    chk("R1 rx_valid", int'(rx_valid), 0);
    chk("R1 flags", int'({parity_err, frame_err, overrun, rx_asleep}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 tx_ready", int'(tx_ready), 1);

    // R2: 8-bit frame, LSB first
    send_tx(9'h0A5);
    chk("R3 ready low after accept", int'(tx_ready), 0);
    decode_tx(8, v, sb);
    chk("R2 8-bit data", int'(v), 'h0A5);
    chk("R2 stop bit", int'(sb), 1);
    chk("R3 ready low in stop bit", int'(tx_ready), 0);
    for (int i = 0; i < 200 && !tx_ready; i++) @(negedge clk);
    chk("R3 ready after stop", int'(tx_ready), 1);

    // R2: 9-bit frame
    nine_bit = 1'b1;
    send_tx(9'h1C3);
    decode_tx(9, v, sb);
    chk("R2 9-bit data", int'(v), 'h1C3);
    chk("R2 9-bit stop", int'(sb), 1);
    nine_bit = 1'b0;

    // R2: frame duration is 10 bit times
    send_tx(9'h0FF);
    n = 1;
    for (int i = 0; i < 2000 && !tx_ready; i++) begin @(negedge clk); n++; end
    chk("R2 frame length in range", int'(n >= 630 && n <= 645), 1);

    // R4: parity generation, even then odd
    parity_en = 1'b1;
    send_tx(9'h013);
    decode_tx(8, v, sb);
    chk("R4 even parity tx", int'(v), int'(with_par8(9'h013, 1'b0)));
    parity_odd = 1'b1;
    send_tx(9'h013);
    decode_tx(8, v, sb);
    chk("R4 odd parity tx", int'(v), int'(with_par8(9'h013, 1'b1)));
    parity_odd = 1'b0;
    parity_en  = 1'b0;
    wait_clk(BIT * 2);

    // R5: plain reception, 8 and 9 bits
    allow_rx = 1'b1;
    drive_frame(9'h05A, 1'b0, 1'b1);
    wait_rx(seen);
    chk("R5 rx 8-bit seen", int'(seen), 1);
    chk("R5 rx 8-bit data", int'(rx_data), 'h05A);
    chk("R5 rx flags clean", int'({parity_err, frame_err, overrun}), 0);
    read_rx();
    chk("R5 valid cleared by read", int'(rx_valid), 0);
    nine_bit = 1'b1;
    drive_frame(9'h155, 1'b1, 1'b1);
    wait_rx(seen);
    chk("R5 rx 9-bit data", int'(rx_data), 'h155);
    read_rx();
    nine_bit = 1'b0;

    // R4: receive parity check (even)
    parity_en = 1'b1;
    drive_frame(9'h007, 1'b0, 1'b1);
    wait_rx(seen);
    chk("R4 parity mismatch flagged", int'(parity_err), 1);
    read_rx();
    drive_frame(9'h087, 1'b0, 1'b1);
    wait_rx(seen);
    chk("R4 parity match clean", int'(parity_err), 0);
    read_rx();
    parity_en = 1'b0;

    // R6: low stop bit; R5: the tail must not start a false character
    drive_frame(9'h033, 1'b0, 1'b0);
    wait_rx(seen);
    chk("R6 framing char data", int'(rx_data), 'h033);
    chk("R6 framing error", int'(frame_err), 1);
    read_rx();
    allow_rx = 1'b0;
    wait_clk(1000);
    chk("R5 false start dropped", int'(rx_valid), 0);

    // R7: overrun keeps the first character
    allow_rx = 1'b1;
    drive_frame(9'h011, 1'b0, 1'b1);
    drive_frame(9'h022, 1'b0, 1'b1);
    chk("R7 overrun set", int'(overrun), 1);
    chk("R7 first kept", int'(rx_data), 'h011);
    read_rx();
    chk("R7 read clears", int'({rx_valid, overrun}), 0);

    // R8: internal loop ignores rxd and pad
    loop_sel  = 1'b1;
    loop_ext  = 1'b0;
    pad_stuck = 1'b1;
    rxd_drv   = 1'b0;
    send_tx(9'h06C);
    wait_clk(BIT * 10);
    wait_rx(seen);
    chk("R8 internal loop data", int'(rx_data), 'h06C);
    read_rx();

    // R9: external loop follows pad, ignores rxd
    loop_ext  = 1'b1;
    pad_stuck = 1'b0;
    send_tx(9'h039);
    wait_clk(BIT * 10);
    wait_rx(seen);
    chk("R9 pad loop data", int'(rx_data), 'h039);
    read_rx();
    pad_stuck = 1'b1;
    allow_rx  = 1'b0;
    send_tx(9'h04E);
    wait_clk(BIT * 12);
    chk("R9 stuck pad gives nothing", int'(rx_valid), 0);
    rxd_drv = 1'b1;
    wait_clk(BIT * 2);

    // R10: loop with transmitter disabled listens on rxd
    allow_rx = 1'b1;
    tx_en    = 1'b0;
    @(negedge clk);
    chk("R3 ready needs tx_en", int'(tx_ready), 0);
    drive_frame(9'h071, 1'b0, 1'b1);
    wait_rx(seen);
    chk("R10 rxd used without both enables", int'(rx_data), 'h071);
    read_rx();
    tx_en     = 1'b1;
    loop_sel  = 1'b0;
    loop_ext  = 1'b0;
    pad_stuck = 1'b0;

    // R11/R12: address-mark wake
    allow_rx  = 1'b0;
    wake_addr = 1'b1;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R11 asleep set", int'(rx_asleep), 1);
    drive_frame(9'h005, 1'b0, 1'b1);
    chk("R11 no strobe while asleep", int'(rx_valid), 0);
    wait_clk(1200);
    chk("R12 idle does not wake in address mode", int'(rx_asleep), 1);
    allow_rx = 1'b1;
    drive_frame(9'h085, 1'b0, 1'b1);
    wait_rx(seen);
    chk("R12 address char delivered", int'(rx_data), 'h085);
    chk("R12 awake", int'(rx_asleep), 0);
    read_rx();

    // R13: idle-line wake after one character time
    allow_rx  = 1'b0;
    wake_addr = 1'b0;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    drive_frame(9'h044, 1'b0, 1'b1);
    chk("R11 sleeping char dropped", int'(rx_valid), 0);
    chk("R13 still asleep at frame end", int'(rx_asleep), 1);
    wait_clk(500);
    chk("R13 still asleep before char time", int'(rx_asleep), 1);
    wait_clk(300);
    chk("R13 idle wake", int'(rx_asleep), 0);

    // R2: divisor 0 stops reception
    baud_div = '0;
    drive_frame(9'h02A, 1'b0, 1'b1);
    wait_clk(200);
    chk("R2 divisor zero receives nothing", int'(rx_valid), 0);
    baud_div = 13'(DIV);
    wait_clk(BIT);

    // R14: halt gating
    stop_in_wait = 1'b1;
    wait_mode    = 1'b1;
    @(negedge clk);
    chk("R14 halted not ready", int'(tx_ready), 0);
    stop_in_wait = 1'b0;
    @(negedge clk);
    chk("R14 wait ignored when not enabled", int'(tx_ready), 1);
    wait_mode    = 1'b0;
    stop_in_wait = 1'b1;
    send_tx(9'h00F);
    n = 1;
    wait_clk(100);
    n += 100;
    wait_mode = 1'b1;
    @(negedge clk);
    n++;
    sb = txd;
    wait_clk(499);
    n += 499;
    chk("R14 txd frozen", int'(txd), int'(sb));
    wait_mode = 1'b0;
    for (int i = 0; i < 2000 && !tx_ready; i++) begin @(negedge clk); n++; end
    chk("R14 frame stretched by halt", int'(n >= 1130 && n <= 1150), 1);
    stop_in_wait = 1'b0;

    finish_run();
  end
endmodule